// File: doc/BRIEF.md
# Debug Port Status and Control Register

This block keeps the status and control bits of one root hub port that has been handed to a debug function. It tracks three fields: a connect flag, a port-enable flag and a port-reset flag. Hardware event strobes drive them: a debug host attaching or detaching, a port fault, the start of a bus reset and its completion. A master debug enable gates the whole register. Software can change only the enable flag, through a 64-bit write port.

The enable flag also moves by itself. It sets one cycle after a rising edge of the connect flag or a falling edge of the reset flag. It clears one cycle after a rising edge of the reset flag. These edges are taken from the registered field values of the previous cycle. The block tells the link what to do next (run normally, look for a receiver, or stay disabled). It also raises a one-cycle request for the device side to return to its default state when a bus reset completes.

Top module: `dbg_port_ctl`

## Requirements
- R1: After reset, `reg_rdata` is all zeros, `link_req` is receiver-detect (1) and `go_default` is 0.
- R2: The connect flag (read bit 0) becomes 1 on the edge that samples `host_conn` while `dbg_en` is 1. `host_disc` clears it on the next edge and wins over a simultaneous `host_conn`. `host_conn` sampled while `dbg_en` is 0 has no effect.
- R3: The enable flag (read bit 1) becomes 1 one edge after the connect flag rises, and one edge after the reset flag falls.
- R4: The reset flag (read bit 4) becomes 1 on the edge that samples `bus_rst_seen` while connected. `bus_rst_done` clears it. If both strobes come together, `bus_rst_seen` wins.
- R5: One edge after the reset flag rises, the enable flag is 0 and `link_req` is receiver-detect (1).
- R6: When `bus_rst_done` clears the reset flag, `go_default` is 1 for exactly the following cycle.
- R7: `port_fault` clears the enable flag on the next edge while the connect flag stays 1, and `link_req` becomes disabled (2).
- R8: A write with `reg_wr` sets the enable flag to `reg_wdata[1]`. All other written bits are ignored. An automatic set of the enable flag in the same cycle wins over a written 0.
- R9: While `dbg_en` is 0, `reg_rdata` reads 0 in that same cycle and `link_req` is receiver-detect. The next edge clears all stored fields, so they stay 0 after `dbg_en` returns until new events arrive.
- R10: `link_req` encodes normal as 0, receiver-detect as 1 and disabled as 2. It is normal whenever the enable flag is 1. With the enable flag at 0, it is receiver-detect after a reset-caused clear and disabled after a fault or a software clear.
- R11: Bits 3:2 and 63:5 of `reg_rdata` always read 0. The enable and reset bits read 0 whenever the connect bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_en | input | 1 | Master debug enable level |
| host_conn | input | 1 | Debug host attach strobe |
| host_disc | input | 1 | Debug host detach strobe |
| port_fault | input | 1 | Port fault strobe |
| bus_rst_seen | input | 1 | Bus reset sequence detected strobe |
| bus_rst_done | input | 1 | Bus reset sequence completed strobe |
| reg_wr | input | 1 | Software write strobe |
| reg_wdata | input | 64 | Software write data; only bit 1 is used |
| reg_rdata | output | 64 | Register read value after masking |
| link_req | output | 2 | Link command: 0 normal, 1 receiver-detect, 2 disabled |
| go_default | output | 1 | One-cycle request to return to the default state |

## Verification
The bench targets the cycle on which each automatic update lands. A design that reacted to the connect or reset strobes directly, instead of to the registered edges, would move the enable flag one cycle early, and the directed sequences would catch this. It also drives conflicts in a single cycle: attach with detach, reset detect with reset done, and a software clear that coincides with a reset-completion edge. A wrong priority there leaves the wrong flag value. Dropping the master enable for a single cycle must clear the stored state, so a design that only masked the read value would show stale flags once the enable returns. A randomized phase compares every output against a cycle model on every cycle.

// File: rtl/dbgp_pkg.sv
// Package: shared widths, field positions and link command codes for the
// debug port status/control register.
package dbgp_pkg;
    localparam int REG_W   = 64;
    localparam int CCS_BIT = 0;   // connect flag position
    localparam int PED_BIT = 1;   // enable flag position
    localparam int PR_BIT  = 4;   // reset flag position
    localparam int EDGE_W  = 2;   // tracked fields: {reset, connect}

    typedef enum logic [1:0] {
        LINK_NORMAL   = 2'd0,
        LINK_RXDET    = 2'd1,
        LINK_DISABLED = 2'd2
    } link_cmd_e;
endpackage

// File: rtl/dbgp_edge.sv
// Module: dbgp_edge
// Registers the previous value of each tracked bit and reports its rising
// and falling edges. Assumes the inputs are registered values, so each
// change yields a single one-cycle edge indication.
module dbgp_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Hold the last-cycle copy of bit i.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= sig[i];
        end
        // Compare current against previous for bit i.
        always_comb begin
            rise[i] = sig[i] & ~prev_q[i];
            fall[i] = ~sig[i] & prev_q[i];
        end
    end
endmodule

// File: rtl/dbgp_fields.sv
// Module: dbgp_fields
// Holds the connect, enable and reset flags, the cause of the last enable
// clear and the default-state pulse. Assumes edge inputs come from
// dbgp_edge, which looks at this module's own registered outputs.
module dbgp_fields (
    input  logic clk,
    input  logic rst_n,
    input  logic dbg_en,
    input  logic conn_evt,
    input  logic disc_evt,
    input  logic fault_evt,
    input  logic rst_det,
    input  logic rst_fin,
    input  logic sw_wr,
    input  logic sw_ped,
    input  logic ccs_rise,
    input  logic pr_rise,
    input  logic pr_fall,
    output logic ccs_q,
    output logic ped_q,
    output logic pr_q,
    output logic cause_rx_q,
    output logic dflt_q
);
    logic ccs_d, keep, pr_d, ped_d, cause_d, dflt_d, auto_set;

    // Next-state rules for every stored field.
    always_comb begin
        ccs_d    = dbg_en && !disc_evt && (conn_evt || ccs_q);
        keep     = dbg_en && ccs_d;
        pr_d     = keep && (rst_det || (pr_q && !rst_fin));
        dflt_d   = keep && pr_q && !rst_det && rst_fin;
        auto_set = ccs_rise || pr_fall;
        ped_d    = ped_q;
        cause_d  = cause_rx_q;
        if (!keep) begin
            ped_d   = 1'b0;
            cause_d = 1'b1;
        end else if (fault_evt) begin
            ped_d   = 1'b0;
            cause_d = 1'b0;
        end else if (pr_rise) begin
            ped_d   = 1'b0;
            cause_d = 1'b1;
        end else if (auto_set) begin
            ped_d   = 1'b1;
        end else if (sw_wr) begin
            ped_d   = sw_ped;
            if (!sw_ped) cause_d = 1'b0;
        end
    end

    // Register the fields; cause starts as receiver-detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccs_q      <= 1'b0;
            ped_q      <= 1'b0;
            pr_q       <= 1'b0;
            cause_rx_q <= 1'b1;
            dflt_q     <= 1'b0;
        end else begin
            ccs_q      <= ccs_d;
            ped_q      <= ped_d;
            pr_q       <= pr_d;
            cause_rx_q <= cause_d;
            dflt_q     <= dflt_d;
        end
    end
endmodule

// File: rtl/dbgp_link.sv
// Module: dbgp_link
// Decodes the link command from the stored fields. Assumes cause_rx is 1
// whenever the enable flag was last cleared by a reset or never set.
module dbgp_link
    import dbgp_pkg::*;
(
    input  logic      dbg_en,
    input  logic      ccs_q,
    input  logic      ped_q,
    input  logic      cause_rx,
    output link_cmd_e cmd
);
    // Select the command from enable state and clear cause.
    always_comb begin
        if (!dbg_en || !ccs_q) cmd = LINK_RXDET;
        else if (ped_q)        cmd = LINK_NORMAL;
        else if (cause_rx)     cmd = LINK_RXDET;
        else                   cmd = LINK_DISABLED;
    end
endmodule

// File: rtl/dbg_port_ctl.sv
// Module: dbg_port_ctl
// Status/control register for one debug-assigned root hub port. It combines
// field storage, edge tracking and link decode, and masks the read value
// with the master enable and the connect flag. Assumes strobes are
// synchronous one-cycle pulses.
module dbg_port_ctl
    import dbgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_en,
    input  logic             host_conn,
    input  logic             host_disc,
    input  logic             port_fault,
    input  logic             bus_rst_seen,
    input  logic             bus_rst_done,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [1:0]       link_req,
    output logic             go_default
);
    logic ccs_q, ped_q, pr_q, cause_rx_q, dflt_q;
    logic [EDGE_W-1:0] edge_rise, edge_fall;
    link_cmd_e link_cmd;
    logic vis_ccs;

    // Only the enable bit of a write is used; the rest are dropped here.
    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[REG_W-1:PED_BIT+1], reg_wdata[PED_BIT-1:0], edge_fall[0]};

    dbgp_edge #(.W(EDGE_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({pr_q, ccs_q}),
        .rise  (edge_rise),
        .fall  (edge_fall)
    );

    dbgp_fields u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .dbg_en     (dbg_en),
        .conn_evt   (host_conn),
        .disc_evt   (host_disc),
        .fault_evt  (port_fault),
        .rst_det    (bus_rst_seen),
        .rst_fin    (bus_rst_done),
        .sw_wr      (reg_wr),
        .sw_ped     (reg_wdata[PED_BIT]),
        .ccs_rise   (edge_rise[0]),
        .pr_rise    (edge_rise[1]),
        .pr_fall    (edge_fall[1]),
        .ccs_q      (ccs_q),
        .ped_q      (ped_q),
        .pr_q       (pr_q),
        .cause_rx_q (cause_rx_q),
        .dflt_q     (dflt_q)
    );

    dbgp_link u_link (
        .dbg_en   (dbg_en),
        .ccs_q    (ccs_q),
        .ped_q    (ped_q),
        .cause_rx (cause_rx_q),
        .cmd      (link_cmd)
    );

    // Assemble the masked read value.
    always_comb begin
        vis_ccs            = ccs_q & dbg_en;
        reg_rdata          = '0;
        reg_rdata[CCS_BIT] = vis_ccs;
        reg_rdata[PED_BIT] = ped_q & vis_ccs;
        reg_rdata[PR_BIT]  = pr_q & vis_ccs;
    end

    assign link_req   = link_cmd;
    assign go_default = dflt_q;
endmodule

// File: rtl/dbg_port_ctl_chk.sv
// Module: dbg_port_ctl_chk
// Assertion checker bound into dbg_port_ctl. Observes ports and the
// stored fields; drives nothing.
module dbg_port_ctl_chk
    import dbgp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             dbg_en,
    input logic             host_disc,
    input logic             bus_rst_seen,
    input logic             ccs_q,
    input logic             ped_q,
    input logic             pr_q,
    input logic [REG_W-1:0] reg_rdata,
    input logic [1:0]       link_req,
    input logic             go_default
);
    // R2: detach always clears the connect flag.
    a_r2_disc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        host_disc |=> !ccs_q);

    // R4: reset detection while staying connected sets the reset flag.
    a_r4_det_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_en && ccs_q && !host_disc && bus_rst_seen) |=> pr_q);

    // R5: a rising reset flag clears the enable flag next cycle.
    a_r5_rise_clears_ped: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pr_q) |=> !ped_q);

    // R6: default request is a single cycle with reset already gone.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        go_default |=> !go_default);
    a_r6_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        go_default |-> !pr_q);

    // R9: master enable low wipes all stored fields.
    a_r9_force_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_en |=> (!ccs_q && !ped_q && !pr_q));

    // R10: enabled port means a normal link command.
    a_r10_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_en && ccs_q && ped_q) |-> (link_req == LINK_NORMAL));

    // R11: reserved bits never read as 1.
    a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[REG_W-1:PR_BIT+1] == '0) && (reg_rdata[PR_BIT-1:PED_BIT+1] == '0));
endmodule

bind dbg_port_ctl dbg_port_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dbg_en       (dbg_en),
    .host_disc    (host_disc),
    .bus_rst_seen (bus_rst_seen),
    .ccs_q        (ccs_q),
    .ped_q        (ped_q),
    .pr_q         (pr_q),
    .reg_rdata    (reg_rdata),
    .link_req     (link_req),
    .go_default   (go_default)
);

// File: tb/sim_dbg_port_ctl.sv
`timescale 1ns/1ps
module sim_dbg_port_ctl;
    logic clk = 1'b0, rst_n = 1'b0;
    logic dbg_en = 1'b0, host_conn = 1'b0, host_disc = 1'b0, port_fault = 1'b0;
    logic bus_rst_seen = 1'b0, bus_rst_done = 1'b0, reg_wr = 1'b0;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic [1:0] link_req;
    logic go_default;

    int checks = 0, fails = 0;
    bit done = 0;

    // Cycle model state.
    bit m_ccs, m_ped, m_pr, m_ccs_p, m_pr_p, m_cause, m_def;

    always #4 clk = ~clk;

    dbg_port_ctl u0 (
        .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .host_conn(host_conn),
        .host_disc(host_disc), .port_fault(port_fault), .bus_rst_seen(bus_rst_seen),
        .bus_rst_done(bus_rst_done), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .link_req(link_req), .go_default(go_default)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] exp_rdata();
        logic [63:0] r = '0;
        bit c = m_ccs & dbg_en;
        r[0] = c; r[1] = m_ped & c; r[4] = m_pr & c;
        return r;
    endfunction

    function automatic logic [1:0] exp_link();
        if (!dbg_en || !m_ccs) return 2'd1;
        if (m_ped) return 2'd0;
        if (m_cause) return 2'd1;
        return 2'd2;
    endfunction

    task automatic model_reset();
        m_ccs = 0; m_ped = 0; m_pr = 0; m_ccs_p = 0; m_pr_p = 0; m_cause = 1; m_def = 0;
    endtask

    // Advance the model by one edge using the inputs currently held.
    task automatic model_step();
        bit cr, prr, prf, ccs_d, keep, pr_d, def_d, ped_d, cause_d;
        cr  = m_ccs && !m_ccs_p;
        prr = m_pr && !m_pr_p;
        prf = !m_pr && m_pr_p;
        ccs_d = dbg_en && !host_disc && (host_conn || m_ccs);
        keep  = dbg_en && ccs_d;
        pr_d  = keep && (bus_rst_seen || (m_pr && !bus_rst_done));
        def_d = keep && m_pr && !bus_rst_seen && bus_rst_done;
        ped_d = m_ped; cause_d = m_cause;
        if (!keep) begin ped_d = 0; cause_d = 1; end
        else if (port_fault) begin ped_d = 0; cause_d = 0; end
        else if (prr) begin ped_d = 0; cause_d = 1; end
        else if (cr || prf) ped_d = 1;
        else if (reg_wr) begin ped_d = reg_wdata[1]; if (!reg_wdata[1]) cause_d = 0; end
        m_ccs_p = m_ccs; m_pr_p = m_pr;
        m_ccs = ccs_d; m_pr = pr_d; m_ped = ped_d; m_cause = cause_d; m_def = def_d;
    endtask

    // Compare all outputs with the model.
    task automatic compare();
        logic [63:0] e = exp_rdata();
        chk(reg_rdata[0] == e[0], "R2 connect bit", reg_rdata, e);
        chk(reg_rdata[1] == e[1], "R3 enable bit", reg_rdata, e);
        chk(reg_rdata[4] == e[4], "R4 reset bit", reg_rdata, e);
        chk((reg_rdata & ~64'h13) == 0, "R11 reserved bits", reg_rdata, 64'h0);
        chk(link_req == exp_link(), "R10 link command", link_req, exp_link());
        chk(go_default == m_def, "R6 default pulse", go_default, m_def);
    endtask

    task automatic idle();
        host_conn = 0; host_disc = 0; port_fault = 0; bus_rst_seen = 0;
        bus_rst_done = 0; reg_wr = 0; reg_wdata = '0;
    endtask

    // One clock: edge, then sample away from it and compare, then clear strobes.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        model_step();
        compare();
        idle();
    endtask

    initial begin
        #(8 * 200000);
        chk(0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0123));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(reg_rdata == 0, "R1 reset rdata", reg_rdata, 0);
        chk(link_req == 2'd1, "R1 reset link", link_req, 1);
        chk(go_default == 0, "R1 reset default", go_default, 0);
        rst_n = 1; dbg_en = 1;
        tick();

        // R2/R3: attach, enable follows one edge later
        host_conn = 1; tick();
        chk(reg_rdata == 64'h1, "R2 attach sets connect", reg_rdata, 64'h1);
        tick();
        chk(reg_rdata == 64'h3, "R3 enable after connect edge", reg_rdata, 64'h3);
        chk(link_req == 2'd0, "R10 normal when enabled", link_req, 0);

        // R8: software clear, other bits ignored
        reg_wr = 1; reg_wdata = ~64'h2; tick();
        chk(reg_rdata == 64'h1, "R8 write clears enable only", reg_rdata, 64'h1);
        chk(link_req == 2'd2, "R10 disabled after software clear", link_req, 2);
        reg_wr = 1; reg_wdata = 64'h2; tick();
        chk(reg_rdata == 64'h3, "R8 write sets enable", reg_rdata, 64'h3);

        // R4/R5/R6: bus reset sequence
        bus_rst_seen = 1; tick();
        chk(reg_rdata == 64'h13, "R4 reset flag set", reg_rdata, 64'h13);
        tick();
        chk(reg_rdata == 64'h11, "R5 enable cleared by reset", reg_rdata, 64'h11);
        chk(link_req == 2'd1, "R5 receiver-detect", link_req, 1);
        bus_rst_seen = 1; bus_rst_done = 1; tick();
        chk(reg_rdata == 64'h11, "R4 detect wins over done", reg_rdata, 64'h11);
        bus_rst_done = 1; tick();
        chk(reg_rdata == 64'h01, "R4 done clears reset", reg_rdata, 64'h01);
        chk(go_default == 1, "R6 default pulse", go_default, 1);
        tick();
        chk(go_default == 0, "R6 pulse one cycle", go_default, 0);
        chk(reg_rdata == 64'h03, "R3 enable after reset falls", reg_rdata, 64'h03);

        // R7: fault
        port_fault = 1; tick();
        chk(reg_rdata == 64'h01, "R7 fault clears enable", reg_rdata, 64'h01);
        chk(link_req == 2'd2, "R7 disabled link", link_req, 2);

        // R8: automatic set beats software clear in the same cycle
        bus_rst_seen = 1; tick();
        tick();
        bus_rst_done = 1; tick();
        reg_wr = 1; reg_wdata = 64'h0; tick();
        chk(reg_rdata == 64'h03, "R8 hardware set wins", reg_rdata, 64'h03);

        // R9: master enable drop
        dbg_en = 0; #1;
        chk(reg_rdata == 0, "R9 immediate mask", reg_rdata, 0);
        chk(link_req == 2'd1, "R9 link receiver-detect", link_req, 1);
        tick();
        host_conn = 1; tick();
        dbg_en = 1; #1;
        chk(reg_rdata == 0, "R9 state cleared and R2 attach ignored", reg_rdata, 0);
        tick();

        // R2: attach and detach together
        host_conn = 1; host_disc = 1; tick();
        chk(reg_rdata == 0, "R2 detach wins", reg_rdata, 0);

        // Random phase against the model.
        for (int i = 0; i < 4000; i++) begin
            dbg_en       = ($urandom % 40) != 0;
            host_conn    = ($urandom % 6) == 0;
            host_disc    = ($urandom % 18) == 0;
            port_fault   = ($urandom % 20) == 0;
            bus_rst_seen = ($urandom % 10) == 0;
            bus_rst_done = ($urandom % 8) == 0;
            reg_wr       = ($urandom % 6) == 0;
            reg_wdata    = {$urandom, $urandom};
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule